// File: doc/BRIEF.md
# Chained Command XOR Engine

This engine computes a parity buffer from a group of source buffers without help from a processor. Software places a chain of command blocks in memory, gives the engine the word address of the first block, and pulses `go`. For each block the engine reads the block's fields and caches its source addresses. It then builds each output beat by reading one word from every source in turn and folding those words into an accumulator. It writes either the XOR or the inverted XOR of each beat to the target buffer. When the beats are finished it writes a status word back into the block and moves to the next block in the chain.

The engine uses a single memory master port with word addressing. A request stays asserted until the memory acknowledges it, and read data is valid in the acknowledge cycle. Only one access is in flight at a time.

Each block is laid out as follows:

| Word | Content |
|------|---------|
| 0 | control |
| 1 | next-link address |
| 2 | target address |
| 3 | status, written by the engine |
| 4 and up | source addresses, one per word |

The control word holds these fields:

| Bits | Field |
|------|-------|
| [4:0] | source count |
| [8] | invert select |
| [9] | last-block flag |
| [31:16] | transfer length in beats |

Top module: `xor_chain_engine`

## Requirements
- R1: In the cycle after reset, busy, done, err and the memory request are all low.
- R2: For a valid block, beat b of the target (at target address + b) equals the XOR of word b of every listed source (at source address + b). Beats are written in ascending order, and each beat is written after all of its source reads.
- R3: When control bit 8 is set, every target beat is the bitwise complement of the XOR.
- R4: The engine decodes a block with control at word 0, next link at word 1, target at word 2, status at word 3 and sources from word 4 up. The control word carries the source count in bits [4:0], invert in bit 8, last in bit 9 and the length in bits [31:16].
- R5: After the final beat of a valid block, the value 1 is written to word 3 of that block.
- R6: After a block's status write, the engine continues with the block at its next link. The chain ends when the last flag is set or the next link is zero. At the end, busy falls and done rises in the same cycle.
- R7: A source count of 0 or above 16 produces no target write. The engine writes status 2 into the block, stops the chain and raises err together with done.
- R8: A block with the maximum count of 16 sources XORs all of them.
- R9: A `go` pulse while busy is high is ignored. The running chain finishes unchanged and no block at the new start address is touched.
- R10: Once a memory request is raised, it stays raised with a stable address, write enable and write data until it is acknowledged.
- R11: A valid block with length 0 produces no target write but still receives status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only when idle |
| start_addr | input | AW | Word address of the first command block |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Chain finished; held until the next start |
| err | output | 1 | Chain stopped on an invalid block |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |

## Verification
Two events can fall on the same clock edge: a new start request, and the final status write that ends a chain. On that edge the engine returns to idle. To provoke the collision, the bench holds `go` high for the whole run with a different start address, so `go` is still high on the edge of the closing status write. The scoreboard judges the result: any write to the other block, or any extra write after the closing status, counts as a mismatch. The bench also checks that the foreign block's status word is still zero after the run.

// File: rtl/xce_pkg.sv
package xce_pkg;
  // command block word offsets
  localparam int OFS_CTL  = 0;
  localparam int OFS_LINK = 1;
  localparam int OFS_TGT  = 2;
  localparam int OFS_STAT = 3;
  localparam int OFS_SRC  = 4;

  // control word fields
  localparam int CNT_LSB  = 0;
  localparam int CNT_W    = 5;
  localparam int INV_BIT  = 8;
  localparam int LAST_BIT = 9;
  localparam int LEN_LSB  = 16;

  // status codes
  localparam int STAT_OK  = 1;
  localparam int STAT_BAD = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTL,
    ST_LINK,
    ST_TGT,
    ST_SADDR,
    ST_DATA,
    ST_WRITE,
    ST_STAT
  } xce_state_e;
endpackage

// File: rtl/xce_srctab.sv
module xce_srctab #(
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] tab [DEPTH];

  always_ff @(posedge clk) begin
    if (we) tab[waddr] <= wdata;
  end

  assign rdata = tab[raddr];
endmodule

// File: rtl/xce_accum.sv
module xce_accum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          first,
  input  logic          invert,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result
);
  logic [DW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (load) acc <= first ? operand : (acc ^ operand);
  end

  assign result = invert ? ~acc : acc;
endmodule

// File: rtl/xor_chain_engine.sv
module xor_chain_engine
  import xce_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int LENW   = 16,
  parameter int MAXSRC = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int TIW = $clog2(MAXSRC);

  xce_state_e       state;
  logic [AW-1:0]    blk_addr, next_addr, tgt_addr;
  logic [CNT_W-1:0] nsrc, src_idx;
  logic [LENW-1:0]  len, beat;
  logic             inv, last_blk, stat_bad;

  logic [CNT_W-1:0] f_cnt;
  logic             f_bad, acked, src_last, beat_last;
  logic [AW-1:0]    tab_rdata;
  logic [DW-1:0]    acc_result;
  logic             tab_we, acc_load;

  assign f_cnt     = mem_rdata[CNT_LSB +: CNT_W];
  assign f_bad     = (f_cnt == '0) || (f_cnt > CNT_W'(MAXSRC));
  assign acked     = mem_req && mem_ack;
  assign src_last  = (src_idx == nsrc - CNT_W'(1));
  assign beat_last = (beat == len - LENW'(1));
  assign tab_we    = (state == ST_SADDR) && acked;
  assign acc_load  = (state == ST_DATA) && acked;

  xce_srctab #(.AW(AW), .DEPTH(MAXSRC)) u_tab (
    .clk  (clk),
    .we   (tab_we),
    .waddr(src_idx[TIW-1:0]),
    .wdata(mem_rdata[AW-1:0]),
    .raddr(src_idx[TIW-1:0]),
    .rdata(tab_rdata)
  );

  xce_accum #(.DW(DW)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .load   (acc_load),
    .first  (src_idx == '0),
    .invert (inv),
    .operand(mem_rdata),
    .result (acc_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      blk_addr  <= '0;
      next_addr <= '0;
      tgt_addr  <= '0;
      nsrc      <= '0;
      src_idx   <= '0;
      len       <= '0;
      beat      <= '0;
      inv       <= 1'b0;
      last_blk  <= 1'b0;
      stat_bad  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            blk_addr <= start_addr;
            state    <= ST_CTL;
          end
        end

        ST_CTL: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= blk_addr + AW'(OFS_CTL);
          end else if (mem_ack) begin
            mem_req  <= 1'b0;
            nsrc     <= f_cnt;
            inv      <= mem_rdata[INV_BIT];
            last_blk <= mem_rdata[LAST_BIT];
            len      <= mem_rdata[LEN_LSB +: LENW];
            stat_bad <= f_bad;
            state    <= f_bad ? ST_STAT : ST_LINK;
          end
        end

        ST_LINK: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= blk_addr + AW'(OFS_LINK);
          end else if (mem_ack) begin
            mem_req   <= 1'b0;
            next_addr <= mem_rdata[AW-1:0];
            state     <= ST_TGT;
          end
        end

        ST_TGT: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= blk_addr + AW'(OFS_TGT);
          end else if (mem_ack) begin
            mem_req  <= 1'b0;
            tgt_addr <= mem_rdata[AW-1:0];
            src_idx  <= '0;
            state    <= ST_SADDR;
          end
        end

        ST_SADDR: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= blk_addr + AW'(OFS_SRC) + AW'(src_idx);
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (src_last) begin
              src_idx <= '0;
              beat    <= '0;
              state   <= (len == '0) ? ST_STAT : ST_DATA;
            end else begin
              src_idx <= src_idx + CNT_W'(1);
            end
          end
        end

        ST_DATA: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= tab_rdata + AW'(beat);
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (src_last) begin
              src_idx <= '0;
              state   <= ST_WRITE;
            end else begin
              src_idx <= src_idx + CNT_W'(1);
            end
          end
        end

        ST_WRITE: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= tgt_addr + AW'(beat);
            mem_wdata <= acc_result;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (beat_last) begin
              state <= ST_STAT;
            end else begin
              beat  <= beat + LENW'(1);
              state <= ST_DATA;
            end
          end
        end

        ST_STAT: begin
          if (!mem_req) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= blk_addr + AW'(OFS_STAT);
            mem_wdata <= stat_bad ? DW'(STAT_BAD) : DW'(STAT_OK);
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (stat_bad || last_blk || (next_addr == '0)) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              err   <= stat_bad;
              state <= ST_IDLE;
            end else begin
              blk_addr <= next_addr;
              state    <= ST_CTL;
            end
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xce_chk.sv
module xce_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !err && !mem_req));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6
  end_flags_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7
  err_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R9
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));

  // R2
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> busy);
endmodule

bind xor_chain_engine xce_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ack  (mem_ack)
);

// File: tb/xor_chain_engine_tb.sv
module xor_chain_engine_tb;
  logic        clk = 1'b0;
  logic        rst, go;
  logic [15:0] start_addr;
  logic        busy, done, err;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];

  int unsigned exp_a[$];
  logic [31:0] exp_d[$];
  string       exp_t[$];
  int tests = 0;
  int fails = 0;
  int hs_viol = 0;
  logic        prev_req, prev_ack;
  logic [15:0] prev_addr;

  always #5 clk = ~clk;

  xor_chain_engine u_dut (
    .clk(clk), .rst(rst), .go(go), .start_addr(start_addr),
    .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:0]];
      if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    logic [15:0] lo;
    lo = a[15:0];
    return {lo * 16'h01F3 ^ 16'hA5C3, ~lo};
  endfunction

  // driver: builds a block and pushes the writes it must cause
  task automatic put_block(input int base, input int cnt, input bit inv, input bit last,
                           input int len, input int nxt, input int tgt,
                           input int src0, input int stride, input bit expect_w, input string tag);
    logic [31:0] x;
    bit bad;
    bad = (cnt == 0) || (cnt > 16);
    mem[base]   = {16'(len), 6'd0, last, inv, 3'd0, 5'(cnt)};
    mem[base+1] = 32'(nxt);
    mem[base+2] = 32'(tgt);
    mem[base+3] = 32'd0;
    if (!bad) begin
      for (int i = 0; i < cnt; i++) begin
        mem[base+4+i] = 32'(src0 + i*stride);
        for (int b = 0; b < len; b++) mem[src0 + i*stride + b] = pat(src0 + i*stride + b);
      end
    end
    if (expect_w) begin
      if (bad) begin
        exp_a.push_back(base+3); exp_d.push_back(32'd2); exp_t.push_back("R7 error status");
      end else begin
        for (int b = 0; b < len; b++) begin
          x = '0;
          for (int i = 0; i < cnt; i++) x ^= mem[src0 + i*stride + b];
          if (inv) x = ~x;
          exp_a.push_back(tgt+b); exp_d.push_back(x); exp_t.push_back(tag);
        end
        exp_a.push_back(base+3); exp_d.push_back(32'd1); exp_t.push_back("R5 ok status");
      end
    end
  endtask

  // monitor: compares each write against the scoreboard, checks handshake
  always @(negedge clk) begin
    if (rst) begin
      prev_req <= 1'b0;
      prev_ack <= 1'b0;
    end else begin
      if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr)) hs_viol++;
      prev_req  <= mem_req;
      prev_ack  <= mem_ack;
      prev_addr <= mem_addr;
      if (mem_req && mem_we && mem_ack) begin
        if (exp_a.size() == 0) begin
          chk(1'b0, "R6 unexpected write", {16'd0, mem_addr, mem_wdata}, 64'd0);
        end else begin
          automatic int unsigned ea = exp_a.pop_front();
          automatic logic [31:0] ed = exp_d.pop_front();
          automatic string       et = exp_t.pop_front();
          chk((mem_addr == 16'(ea)) && (mem_wdata == ed), et,
              {16'd0, mem_addr, mem_wdata}, {16'd0, 16'(ea), ed});
        end
      end
    end
  end

  task automatic run(input int start, input bit exp_err, input string tag);
    int n;
    @(negedge clk);
    start_addr = 16'(start);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, {tag, " R6 done"}, 64'(done), 64'd1);
    chk(busy == 1'b0, {tag, " R6 busy low"}, 64'(busy), 64'd0);
    chk(err == exp_err, {tag, " err flag"}, 64'(err), 64'(exp_err));
    chk(exp_a.size() == 0, {tag, " R6 all writes seen"}, 64'(exp_a.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    rst = 1'b1; go = 1'b0; start_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(!busy && !done && !err && !mem_req, "R1 reset state",
        {60'd0, busy, done, err, mem_req}, 64'd0);

    // single block, three sources, XOR, last flag set with nonzero link (R2 R4 R6)
    put_block(32'h000, 3, 1'b0, 1'b1, 4, 32'h020, 32'h300, 32'h100, 8, 1'b1, "R2 xor beat");
    run(32'h000, 1'b0, "R4 single");
    chk(mem[32'h023] == 32'd0, "R6 last flag stops chain", 64'(mem[32'h023]), 64'd0);

    // two-block chain: XNOR, then 16 sources ending on a zero link (R3 R8 R6)
    put_block(32'h040, 2, 1'b1, 1'b0, 2, 32'h060, 32'h310, 32'h180, 8, 1'b1, "R3 xnor beat");
    put_block(32'h060, 16, 1'b0, 1'b0, 1, 32'h000, 32'h318, 32'h120, 4, 1'b1, "R8 sixteen sources");
    run(32'h040, 1'b0, "R6 chain");

    // good block then count 17 (R7)
    put_block(32'h080, 1, 1'b0, 1'b0, 3, 32'h0A0, 32'h330, 32'h1B0, 4, 1'b1, "R2 single source");
    put_block(32'h0A0, 17, 1'b0, 1'b0, 2, 32'h0E0, 32'h338, 32'h1B8, 4, 1'b1, "R7");
    run(32'h080, 1'b1, "R7 count 17");
    chk(mem[32'h338] == 32'd0, "R7 no target write", 64'(mem[32'h338]), 64'd0);

    // count 0 alone (R7)
    put_block(32'h0C0, 0, 1'b0, 1'b1, 2, 32'h000, 32'h340, 32'h1B8, 4, 1'b1, "R7");
    run(32'h0C0, 1'b1, "R7 count 0");

    // length zero (R11)
    put_block(32'h0E0, 2, 1'b0, 1'b1, 0, 32'h000, 32'h348, 32'h1B8, 4, 1'b1, "R11 no beat");
    run(32'h0E0, 1'b0, "R11 length 0");
    chk(mem[32'h348] == 32'd0, "R11 target untouched", 64'(mem[32'h348]), 64'd0);

    // go held high through the whole run, pointing elsewhere (R9)
    put_block(32'h1C0, 4, 1'b0, 1'b1, 3, 32'h000, 32'h320, 32'h190, 8, 1'b1, "R9 xor beat");
    @(negedge clk);
    start_addr = 16'h01C0;
    go = 1'b1;
    @(negedge clk);
    start_addr = 16'h01E0;
    for (int n = 0; n < 20000 && !done; n++) @(negedge clk);
    go = 1'b0;
    chk(done == 1'b1, "R9 done", 64'(done), 64'd1);
    chk(err == 1'b0, "R9 no error", 64'(err), 64'd0);
    @(negedge clk);
    chk(busy == 1'b0, "R9 no restart", 64'(busy), 64'd0);
    chk(mem[32'h1E3] == 32'd0, "R9 foreign block untouched", 64'(mem[32'h1E3]), 64'd0);
    chk(exp_a.size() == 0, "R9 all writes seen", 64'(exp_a.size()), 64'd0);

    // R10
    chk(hs_viol == 0, "R10 request held until ack", 64'(hs_viol), 64'd0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule